// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block holds the hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Operands are read in decode and results are written only in writeback, so read-after-write is the only hazard it has to resolve. For the instruction sitting in the decode/execute register, it compares both source register numbers with the destinations in the execute/memory and memory/writeback registers. From that comparison it drives a 2-bit bypass select for each ALU operand. A third select lets a store in the memory stage take its data from the result currently in writeback.

Forwarding cannot cover one case: a load followed at once by an instruction that needs the loaded value in execute. For that case the block compares the load's destination with the source fields of the instruction word in the fetch/decode register. When they match, it holds the program counter and the fetch/decode register and asks for a bubble in decode/execute, which costs exactly one cycle. The block is purely combinational. Its clock and reset only qualify the built-in property checks. The register file, ALU, memories and branch logic are outside the block.

Top module: `fwd_stall_unit`

## Requirements
- R1: Each operand select `fwd_a_sel`/`fwd_b_sel` uses the code 2'b00 = register file, 2'b10 = execute/memory result, 2'b01 = memory/writeback result. The code 2'b11 never appears.
- R2: An operand select is 2'b10 whenever `exmem_reg_write` is 1 and `exmem_dst` equals that operand's source (`idex_rs` for A, `idex_rt` for B) and is non-zero.
- R3: An operand select is 2'b01 when `memwb_reg_write` is 1, `memwb_dst` equals the source and is non-zero, and R2 does not apply. Otherwise the select is 2'b00.
- R4: When both the execute/memory and memory/writeback destinations match a source, the execute/memory result (the younger one) wins with 2'b10.
- R5: Register 0 is never bypassed and never causes a stall: a source or destination of 0 gives select 2'b00 and no hold.
- R6: A load-use stall raises `pc_hold`, `ifid_hold` and `idex_bubble` together, in the same cycle as the cause. The cause is `idex_mem_read` = 1 with a non-zero `idex_dst` that equals the fetch/decode source field at `ifid_instr[25:21]`.
- R7: A match of `idex_dst` with the second source field `ifid_instr[20:16]` stalls only when `ifid_rt_used` is 1 and `ifid_is_store` is 0. A store's data register never stalls; it is covered by R8.
- R8: `st_data_sel` is 1 exactly when `exmem_is_store` is 1, `memwb_reg_write` is 1, and `memwb_dst` equals `exmem_rt` and is non-zero. Otherwise it is 0.
- R9: With `idex_mem_read` at 0, none of the three hold outputs rises, whatever the register fields are.
- R10: All outputs follow their inputs within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the property checks |
| rst_n | input | 1 | Active-low reset, disables the property checks |
| ifid_instr | input | 32 | Instruction word in the fetch/decode register |
| ifid_rt_used | input | 1 | That instruction reads its field at bits 20:16 |
| ifid_is_store | input | 1 | That instruction is a store |
| idex_rs | input | 5 | First source of the instruction in decode/execute |
| idex_rt | input | 5 | Second source of the instruction in decode/execute |
| idex_mem_read | input | 1 | Decode/execute instruction is a load |
| idex_dst | input | 5 | Destination of the decode/execute instruction |
| exmem_reg_write | input | 1 | Execute/memory instruction writes a register |
| exmem_dst | input | 5 | Destination in execute/memory |
| exmem_is_store | input | 1 | Execute/memory instruction is a store |
| exmem_rt | input | 5 | Store data register of the execute/memory instruction |
| memwb_reg_write | input | 1 | Memory/writeback instruction writes a register |
| memwb_dst | input | 5 | Destination in memory/writeback |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| st_data_sel | output | 1 | Store data taken from the writeback result |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Clear the decode/execute control bits |

## Verification
The hardest situation to reach is three hits on the same register at once. Both pipeline destinations match one source, a load in decode/execute matches the next instruction, and a store waits on writeback data, all while register 0 appears in some of these fields. Free random register numbers almost never line up like that. The stimulus therefore draws every register field from the four values 0 to 3, so coincident matches and register-0 cases occur in most cycles. Directed cycles then pin the priority, the store exemption and the zero-register cases.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   typedef enum logic [1:0] {
      FWD_RF = 2'b00,
      FWD_MW = 2'b01,
      FWD_XM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fsu_fwd_pick.sv
module fsu_fwd_pick
   import fsu_pkg::*;
#(
   parameter int RA_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] src,
   input  logic            xm_wr,
   input  logic [RA_W-1:0] xm_dst,
   input  logic            mw_wr,
   input  logic [RA_W-1:0] mw_dst,
   output fwd_sel_e        sel
);
   localparam logic [RA_W-1:0] ZERO_REG = '0;

   logic src_live;
   logic hit_xm;
   logic hit_mw;

   assign src_live = (src != ZERO_REG);
   assign hit_xm   = xm_wr && src_live && (xm_dst == src);
   assign hit_mw   = mw_wr && src_live && (mw_dst == src);

   always_comb begin
      sel = FWD_RF;
      if (hit_xm)      sel = FWD_XM;
      else if (hit_mw) sel = FWD_MW;
   end

   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sel != fwd_sel_e'(2'b11)); // R1
   AST_XM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == FWD_XM) |-> (xm_wr && (xm_dst == src) && (src != '0))); // R2
   AST_MW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == FWD_MW) |-> (mw_wr && (mw_dst == src) && (src != '0))); // R3
   AST_YOUNG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == FWD_MW) |-> !(xm_wr && (xm_dst == src))); // R4
   AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> (sel == FWD_RF)); // R5
endmodule

// File: rtl/fsu_load_use.sv
module fsu_load_use #(
   parameter int  RA_W        = 5,
   parameter bit  STORE_EXEMPT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] nxt_rs,
   input  logic [RA_W-1:0] nxt_rt,
   input  logic            nxt_rt_used,
   input  logic            nxt_is_store,
   input  logic            ld_valid,
   input  logic [RA_W-1:0] ld_dst,
   output logic            stall
);
   localparam logic [RA_W-1:0] ZERO_REG = '0;

   logic ld_live;
   logic hit_rs;
   logic hit_rt;
   logic rt_counts;

   assign ld_live = ld_valid && (ld_dst != ZERO_REG);
   assign hit_rs  = (ld_dst == nxt_rs);
   assign hit_rt  = (ld_dst == nxt_rt);

   generate
      if (STORE_EXEMPT) begin : g_exempt
         assign rt_counts = nxt_rt_used && !nxt_is_store;
      end else begin : g_no_exempt
         assign rt_counts = nxt_rt_used;
      end
   endgenerate

   assign stall = ld_live && (hit_rs || (rt_counts && hit_rt));

   AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> !stall); // R9
   AST_STALL_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_dst == '0) |-> !stall); // R5
   AST_STALL_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ((ld_dst == nxt_rs) || (ld_dst == nxt_rt))); // R6
endmodule

// File: rtl/fsu_store_fwd.sv
module fsu_store_fwd #(
   parameter int RA_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_valid,
   input  logic [RA_W-1:0] st_reg,
   input  logic            wb_wr,
   input  logic [RA_W-1:0] wb_dst,
   output logic            use_wb
);
   localparam logic [RA_W-1:0] ZERO_REG = '0;

   logic reg_live;
   assign reg_live = (st_reg != ZERO_REG);
   assign use_wb   = st_valid && wb_wr && reg_live && (wb_dst == st_reg);

   AST_STORE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      use_wb |-> (st_valid && (wb_dst == st_reg))); // R8
   AST_STORE_R0: assert property (@(posedge clk) disable iff (!rst_n)
      (st_reg == '0) |-> !use_wb); // R5
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
   import fsu_pkg::*;
#(
   parameter int INSTR_W      = 32,
   parameter int RA_W         = 5,
   parameter int RS_LSB       = 21,
   parameter int RT_LSB       = 16,
   parameter bit STORE_FWD_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] ifid_instr,
   input  logic               ifid_rt_used,
   input  logic               ifid_is_store,
   input  logic [RA_W-1:0]    idex_rs,
   input  logic [RA_W-1:0]    idex_rt,
   input  logic               idex_mem_read,
   input  logic [RA_W-1:0]    idex_dst,
   input  logic               exmem_reg_write,
   input  logic [RA_W-1:0]    exmem_dst,
   input  logic               exmem_is_store,
   input  logic [RA_W-1:0]    exmem_rt,
   input  logic               memwb_reg_write,
   input  logic [RA_W-1:0]    memwb_dst,
   output logic [1:0]         fwd_a_sel,
   output logic [1:0]         fwd_b_sel,
   output logic               st_data_sel,
   output logic               pc_hold,
   output logic               ifid_hold,
   output logic               idex_bubble
);
   localparam int NUM_OPS = 2;
   localparam int RS_MSB  = RS_LSB + RA_W - 1;
   localparam int RT_MSB  = RT_LSB + RA_W - 1;

   if (RS_MSB >= INSTR_W || RT_MSB >= INSTR_W) begin : g_chk_fit
      $error("register field lies outside the instruction word");
   end
   if (RA_W < 1 || RA_W > 8) begin : g_chk_ra
      $error("register address width out of range");
   end
   if ((RS_LSB > RT_LSB) ? (RS_LSB < RT_MSB + 1) : (RT_LSB < RS_MSB + 1)) begin : g_chk_ovl
      $error("register fields overlap");
   end

   logic [RA_W-1:0] nxt_rs;
   logic [RA_W-1:0] nxt_rt;
   assign nxt_rs = ifid_instr[RS_MSB:RS_LSB];
   assign nxt_rt = ifid_instr[RT_MSB:RT_LSB];

   logic [RA_W-1:0] op_src [NUM_OPS];
   fwd_sel_e        op_sel [NUM_OPS];
   assign op_src[0] = idex_rs;
   assign op_src[1] = idex_rt;

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      fsu_fwd_pick #(.RA_W(RA_W)) u_pick (
         .clk    (clk),
         .rst_n  (rst_n),
         .src    (op_src[i]),
         .xm_wr  (exmem_reg_write),
         .xm_dst (exmem_dst),
         .mw_wr  (memwb_reg_write),
         .mw_dst (memwb_dst),
         .sel    (op_sel[i])
      );
   end

   assign fwd_a_sel = op_sel[0];
   assign fwd_b_sel = op_sel[1];

   logic stall;
   fsu_load_use #(.RA_W(RA_W), .STORE_EXEMPT(STORE_FWD_EN)) u_load_use (
      .clk          (clk),
      .rst_n        (rst_n),
      .nxt_rs       (nxt_rs),
      .nxt_rt       (nxt_rt),
      .nxt_rt_used  (ifid_rt_used),
      .nxt_is_store (ifid_is_store),
      .ld_valid     (idex_mem_read),
      .ld_dst       (idex_dst),
      .stall        (stall)
   );

   generate
      if (STORE_FWD_EN) begin : g_stfwd
         fsu_store_fwd #(.RA_W(RA_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .st_valid (exmem_is_store),
            .st_reg   (exmem_rt),
            .wb_wr    (memwb_reg_write),
            .wb_dst   (memwb_dst),
            .use_wb   (st_data_sel)
         );
      end else begin : g_no_stfwd
         assign st_data_sel = 1'b0;
      end
   endgenerate

   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   AST_HOLD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hold == ifid_hold) && (ifid_hold == idex_bubble)); // R6
   AST_NO_LOAD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !idex_mem_read |-> !(pc_hold || ifid_hold || idex_bubble)); // R9
   AST_STORE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_is_store && (idex_dst != nxt_rs)) |-> !pc_hold); // R7
endmodule

// File: tb/fwd_stall_unit_bench.sv
module fwd_stall_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ifid_instr = '0;
   logic        ifid_rt_used = 1'b0, ifid_is_store = 1'b0;
   logic [4:0]  idex_rs = '0, idex_rt = '0, idex_dst = '0;
   logic        idex_mem_read = 1'b0;
   logic        exmem_reg_write = 1'b0, exmem_is_store = 1'b0;
   logic [4:0]  exmem_dst = '0, exmem_rt = '0;
   logic        memwb_reg_write = 1'b0;
   logic [4:0]  memwb_dst = '0;
   logic [1:0]  fwd_a_sel, fwd_b_sel;
   logic        st_data_sel, pc_hold, ifid_hold, idex_bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fwd_stall_unit u_fwd_stall_unit (
      .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr),
      .ifid_rt_used(ifid_rt_used), .ifid_is_store(ifid_is_store),
      .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_mem_read(idex_mem_read),
      .idex_dst(idex_dst), .exmem_reg_write(exmem_reg_write),
      .exmem_dst(exmem_dst), .exmem_is_store(exmem_is_store),
      .exmem_rt(exmem_rt), .memwb_reg_write(memwb_reg_write),
      .memwb_dst(memwb_dst), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .st_data_sel(st_data_sel), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
      .idex_bubble(idex_bubble)
   );

   // reference: which pipeline result a source should take
   function automatic logic [1:0] want_sel(input logic [4:0] s);
      int code;
      code = 0;                                            // register file
      if (s != 0) begin
         if (memwb_reg_write && memwb_dst == s) code = 1;  // older result
         if (exmem_reg_write && exmem_dst == s) code = 2;  // younger overrides
      end
      return code[1:0];
   endfunction

   function automatic logic want_hold();
      logic [4:0] a, b;
      a = ifid_instr[25:21];
      b = ifid_instr[20:16];
      if (!idex_mem_read || idex_dst == 0) return 1'b0;
      if (idex_dst == a) return 1'b1;
      if (ifid_rt_used && !ifid_is_store && idex_dst == b) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic want_st();
      return exmem_is_store && memwb_reg_write && memwb_dst != 0 && memwb_dst == exmem_rt;
   endfunction

   task automatic check(input string tag_fwd, input string tag_hold, input string tag_st);
      logic [1:0] ea, eb;
      logic eh, es;
      #1;
      ea = want_sel(idex_rs);
      eb = want_sel(idex_rt);
      eh = want_hold();
      es = want_st();
      checks++;
      if (fwd_a_sel !== ea) begin
         errors++;
         $display("FAIL %s fwd_a_sel actual %b expected %b", tag_fwd, fwd_a_sel, ea);
      end
      checks++;
      if (fwd_b_sel !== eb) begin
         errors++;
         $display("FAIL %s fwd_b_sel actual %b expected %b", tag_fwd, fwd_b_sel, eb);
      end
      checks++;
      if ({pc_hold, ifid_hold, idex_bubble} !== {3{eh}}) begin
         errors++;
         $display("FAIL %s holds actual %b%b%b expected %b%b%b", tag_hold,
                  pc_hold, ifid_hold, idex_bubble, eh, eh, eh);
      end
      checks++;
      if (st_data_sel !== es) begin
         errors++;
         $display("FAIL %s st_data_sel actual %b expected %b", tag_st, st_data_sel, es);
      end
   endtask

   task automatic clear_all();
      ifid_instr = '0; ifid_rt_used = 0; ifid_is_store = 0;
      idex_rs = 0; idex_rt = 0; idex_mem_read = 0; idex_dst = 0;
      exmem_reg_write = 0; exmem_dst = 0; exmem_is_store = 0; exmem_rt = 0;
      memwb_reg_write = 0; memwb_dst = 0;
   endtask

   task automatic set_next(input logic [4:0] a, input logic [4:0] b);
      ifid_instr = {6'h23, a, b, 16'h1234};
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      check("R10_reset", "R10_reset", "R10_reset");

      // R2: EX/MEM hit on operand A
      @(negedge clk) clear_all();
      idex_rs = 5'd7; exmem_reg_write = 1; exmem_dst = 5'd7;
      check("R2", "R9", "R8");
      // R3: MEM/WB hit on operand B
      @(negedge clk) clear_all();
      idex_rt = 5'd9; memwb_reg_write = 1; memwb_dst = 5'd9;
      check("R3", "R9", "R8");
      // R4: both stages match, younger wins
      @(negedge clk) clear_all();
      idex_rs = 5'd4; idex_rt = 5'd4;
      exmem_reg_write = 1; exmem_dst = 5'd4; memwb_reg_write = 1; memwb_dst = 5'd4;
      check("R4", "R9", "R8");
      // R5: register 0 everywhere
      @(negedge clk) clear_all();
      exmem_reg_write = 1; memwb_reg_write = 1; idex_mem_read = 1;
      exmem_is_store = 1; set_next(5'd0, 5'd0); ifid_rt_used = 1;
      check("R5", "R5", "R5");
      // R6: load-use on first source
      @(negedge clk) clear_all();
      idex_mem_read = 1; idex_dst = 5'd12; set_next(5'd12, 5'd3);
      check("R1", "R6", "R8");
      // R7: second source, used, not a store -> stall
      @(negedge clk) clear_all();
      idex_mem_read = 1; idex_dst = 5'd6; set_next(5'd1, 5'd6); ifid_rt_used = 1;
      check("R1", "R7", "R8");
      // R7: store data register -> no stall
      @(negedge clk) ifid_is_store = 1;
      check("R1", "R7", "R8");
      // R7: second field not read -> no stall
      @(negedge clk) ifid_is_store = 0; ifid_rt_used = 0;
      check("R1", "R7", "R8");
      // R8: store takes writeback data
      @(negedge clk) clear_all();
      exmem_is_store = 1; exmem_rt = 5'd21; memwb_reg_write = 1; memwb_dst = 5'd21;
      check("R1", "R9", "R8");
      // R9: match but no load
      @(negedge clk) clear_all();
      idex_dst = 5'd5; set_next(5'd5, 5'd5); ifid_rt_used = 1;
      check("R1", "R9", "R8");

      // random cycles, small register range so matches are frequent
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         ifid_instr    = $urandom();
         ifid_instr[25:21] = 5'($urandom_range(0, 3));
         ifid_instr[20:16] = 5'($urandom_range(0, 3));
         ifid_rt_used  = 1'($urandom_range(0, 1));
         ifid_is_store = 1'($urandom_range(0, 1));
         idex_rs       = 5'($urandom_range(0, 3));
         idex_rt       = 5'($urandom_range(0, 3));
         idex_mem_read = 1'($urandom_range(0, 1));
         idex_dst      = 5'($urandom_range(0, 3));
         exmem_reg_write = 1'($urandom_range(0, 1));
         exmem_dst     = 5'($urandom_range(0, 3));
         exmem_is_store  = 1'($urandom_range(0, 1));
         exmem_rt      = 5'($urandom_range(0, 3));
         memwb_reg_write = 1'($urandom_range(0, 1));
         memwb_dst     = 5'($urandom_range(0, 3));
         check("R4", "R6", "R8");
      end

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule